// File: doc/BRIEF.md
# Serial Port with Modem Lines

This block is an asynchronous serial transmitter and receiver for a chip's peripheral bus. Each direction has a single byte of buffering. A mode byte sets the character format: 7 or 8 data bits, parity off, even or odd, and one or two stop bits. The same byte carries a clock divisor field. Together with the baud byte, that divisor sets the bit rate from the system clock. The receiver oversamples the line and confirms each start bit halfway through it. It reports parity, framing and overrun errors.

The block drives two modem outputs, one for request-to-send and one for data-terminal-ready. It watches four modem inputs: clear-to-send, data-set-ready, carrier detect and ring. It can raise a flag when any of those inputs changes. A null-modem setting replaces the external modem inputs with the block's own outputs. When hardware flow control is selected, each character waits for clear-to-send. A single interrupt line combines four enabled event sources.

Software reaches the block through byte-wide registers placed every four bytes. A read has a side effect in the clock cycle where `rd_en` is high. Reading the data register releases the receive buffer. Reading the status register clears the error flags. Reading the modem-status register clears the change flag.

Top module: `uart_modem`

## Requirements
- R1: After reset, the control, mode, baud and modem-control registers (offsets 0x00, 0x04, 0x08, 0x14) read 0x00, the status register (0x0C) reads 0x02, txd is 1, and irq, rts_o and dtr_o are 0. Written values read back unchanged from those four registers.
- R2: One serial bit lasts (baud+1)·(div+1)·16 clock cycles, where div is mode bits 7:4.
- R3: A transmitted frame has the following parts, in order:
  - a start bit of 0;
  - the data bits, LSB first: 7 of them when mode bit 0 is 1, otherwise 8;
  - a parity bit when mode bit 1 is 1, making the count of ones in the data and parity bits even (mode bit 2 = 0) or odd (mode bit 2 = 1);
  - one stop bit of 1, or two when mode bit 3 is 1.
  The line idles at 1.
- R4: Writing the data register (0x10) while control bit 1 is 1 and the transmit buffer is empty loads that buffer, and status bit 1 (buffer empty) clears. A write made while the transmitter is disabled or the buffer is full is ignored. Status bit 3 is 1 while a frame is being sent.
- R5: When control bit 0 is 1, a received character appears in the data register and sets status bit 0. A 7-bit character reads with bit 7 at 0. Reading the data register clears status bit 0. With control bit 0 at 0, nothing is received.
- R6: A parity mismatch sets status bit 4. A stop bit sampled as 0 sets status bit 5.
- R7: If a character completes while status bit 0 is 1, status bit 6 (overrun) is set and the buffered byte is kept. Reading the status register clears bits 6:4.
- R8: Modem-control bit 0 drives rts_o and bit 1 drives dtr_o. The modem-status register (0x20) shows, in bits 3:0, ring, carrier, data-set-ready and clear-to-send, in that order from bit 3 down. When modem-control bit 3 is 1, clear-to-send follows rts_o, data-set-ready and carrier follow dtr_o, and ring reads 0.
- R9: While modem-control bit 2 is 1, any change of the four modem lines sets status bit 7. Reading 0x20 clears it. While modem-control bit 2 is 0, a change leaves the flag alone.
- R10: When control bit 3 is 1, a character starts only while clear-to-send is asserted. When control bit 3 is 0, clear-to-send has no effect.
- R11: irq is 1 when any enabled source is active:
  - control bit 7 with status bit 7;
  - control bit 6 with any of status bits 6:4;
  - control bit 5 with status bit 1;
  - control bit 4 with status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe; applies read side effects on the clock edge |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| cts_i | input | 1 | Clear-to-send, 1 = asserted |
| dsr_i | input | 1 | Data-set-ready, 1 = asserted |
| dcd_i | input | 1 | Carrier detect, 1 = asserted |
| ri_i | input | 1 | Ring indicator, 1 = asserted |
| rts_o | output | 1 | Request-to-send, 1 = asserted |
| dtr_o | output | 1 | Data-terminal-ready, 1 = asserted |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: 16 samples per bit and a two-stage input synchronizer. It programs baud values 0 to 2 and divisor values 0 and 1, which gives bit periods of 16 to 64 clocks. At those rates every character format, including 7-bit with odd parity and two stop bits, completes in a few hundred cycles. Looping txd back to rxd tests the transmitter against the receiver. Driving rxd from the bench lets it inject bad parity, bad stop bits and back-to-back characters.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 12;
  localparam int LIM_W   = 13;

  localparam logic [5:0] OFS_CTRL  = 6'h00;
  localparam logic [5:0] OFS_MODE  = 6'h04;
  localparam logic [5:0] OFS_BAUD  = 6'h08;
  localparam logic [5:0] OFS_STAT  = 6'h0C;
  localparam logic [5:0] OFS_DATA  = 6'h10;
  localparam logic [5:0] OFS_MCTL  = 6'h14;
  localparam logic [5:0] OFS_MSTAT = 6'h20;

  // order matches mode bits 3..0
  typedef struct packed {
    logic stop2;
    logic par_odd;
    logic par_en;
    logic len7;
  } fmt_t;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rxres_t;

  function automatic logic [3:0] frame_bits(fmt_t f);
    return 4'd1 + (f.len7 ? 4'd7 : 4'd8) + {3'd0, f.par_en} + (f.stop2 ? 4'd2 : 4'd1);
  endfunction

  function automatic logic par_bit(logic [BYTE_W-1:0] d, fmt_t f);
    logic [BYTE_W-1:0] m;
    m = f.len7 ? {1'b0, d[6:0]} : d;
    return (^m) ^ f.par_odd;
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(logic [BYTE_W-1:0] d, fmt_t f);
    logic [FRAME_W-1:0] fr;
    int pos;
    fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < BYTE_W; i++)
      if (i < 7 || !f.len7) fr[1+i] = d[i];
    pos = f.len7 ? 8 : 9;
    if (f.par_en) fr[pos] = par_bit(d, f);
    return fr;
  endfunction

  // b[0] is the first bit after the start bit
  function automatic rxres_t split_frame(logic [FRAME_W-2:0] b, fmt_t f);
    rxres_t r;
    int pos;
    r.data = f.len7 ? {1'b0, b[6:0]} : b[7:0];
    pos = f.len7 ? 7 : 8;
    r.perr = 1'b0;
    if (f.par_en) begin
      r.perr = (b[pos] != par_bit(r.data, f));
      pos++;
    end
    r.ferr = !b[pos];
    if (f.stop2) r.ferr = r.ferr | !b[pos+1];
    return r;
  endfunction

  function automatic logic [LIM_W-1:0] tick_limit(logic [7:0] baud, logic [3:0] dv);
    logic [LIM_W-1:0] a;
    logic [LIM_W-1:0] b;
    a = {5'd0, baud} + 1'b1;
    b = {9'd0, dv} + 1'b1;
    return LIM_W'(a * b - 1'b1);
  endfunction
endpackage

// File: rtl/uart_modem_baud.sv
module uart_modem_baud
  import uart_modem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] lim,
  output logic             tick
);
  logic [LIM_W-1:0] cnt;

  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && $stable(lim) && lim != '0) |-> !tick);
endmodule

// File: rtl/uart_modem_tx.sv
module uart_modem_tx
  import uart_modem_pkg::*;
#(
  parameter int OVS = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ld,
  input  logic [BYTE_W-1:0] ld_data,
  input  fmt_t              fmt,
  input  logic              go_ok,
  output logic              txd,
  output logic              busy,
  output logic              thr_full,
  output logic              start
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [BYTE_W-1:0]  thr;
  logic [FRAME_W-1:0] sh;
  logic [3:0]         nleft;
  logic [SUB_W-1:0]   sub;

  assign start = !busy && thr_full && go_ok;
  assign txd   = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr      <= '0;
      thr_full <= 1'b0;
      busy     <= 1'b0;
      sh       <= '1;
      nleft    <= '0;
      sub      <= '0;
    end else begin
      if (ld) begin
        thr      <= ld_data;
        thr_full <= 1'b1;
      end
      if (start) begin
        sh       <= build_frame(thr, fmt);
        nleft    <= frame_bits(fmt);
        sub      <= '0;
        busy     <= 1'b1;
        thr_full <= 1'b0;
      end else if (busy && tick) begin
        if (sub == SUB_LAST) begin
          sub   <= '0;
          sh    <= {1'b1, sh[FRAME_W-1:1]};
          nleft <= nleft - 1'b1;
          if (nleft == 4'd1) busy <= 1'b0;
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
endmodule

// File: rtl/uart_modem_rx.sv
module uart_modem_rx
  import uart_modem_pkg::*;
#(
  parameter int OVS = 16
)(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   rxd_s,
  input  logic   en,
  input  fmt_t   fmt,
  output logic   done,
  output rxres_t res,
  output logic   active
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;

  rx_st_t             st;
  logic [SUB_W-1:0]   sub;
  logic [3:0]         idx;
  logic [FRAME_W-2:0] bits_q;
  logic [3:0]         last_idx;

  assign last_idx = frame_bits(fmt) - 4'd2;
  assign res      = split_frame(bits_q, fmt);
  assign active   = (st != RX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      sub    <= '0;
      idx    <= '0;
      bits_q <= '1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        RX_IDLE: if (en && !rxd_s) begin
          st  <= RX_START;
          sub <= '0;
        end
        RX_START: if (tick) begin
          if (sub == SUB_HALF) begin
            sub <= '0;
            idx <= '0;
            st  <= rxd_s ? RX_IDLE : RX_BITS;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        RX_BITS: if (tick) begin
          if (sub == SUB_LAST) begin
            sub         <= '0;
            bits_q[idx] <= rxd_s;
            idx         <= idx + 1'b1;
            if (idx == last_idx) begin
              st   <= RX_IDLE;
              done <= 1'b1;
            end
          end else begin
            sub <= sub + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/uart_modem.sv
module uart_modem
  import uart_modem_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 6
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              txd,
  input  logic              rxd,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              dcd_i,
  input  logic              ri_i,
  output logic              rts_o,
  output logic              dtr_o,
  output logic              irq
);
  localparam int NIN = 5;
  localparam logic [NIN-1:0] SY_RST = 5'b00001;

  logic [BYTE_W-1:0] ctrl, mode, baud, mctl, rbr, status;
  logic rx_full, ovr, ferr, perr, msc;
  logic [3:0] prev_ml, ml, ext_ml;

  // input synchronizers: {ri, dcd, dsr, cts, rxd}
  logic [NIN-1:0] sy [SYNC_STAGES];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy[0] <= SY_RST;
    else        sy[0] <= {ri_i, dcd_i, dsr_i, cts_i, rxd};
  end
  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy[g] <= SY_RST;
      else        sy[g] <= sy[g-1];
    end
  end

  logic rxd_s, cts_eff;
  assign rxd_s  = sy[SYNC_STAGES-1][0];
  assign ext_ml = sy[SYNC_STAGES-1][4:1];
  assign ml     = mctl[3] ? {1'b0, mctl[1], mctl[1], mctl[0]} : ext_ml;
  assign cts_eff = ml[0];
  assign rts_o  = mctl[0];
  assign dtr_o  = mctl[1];

  // register strobes
  logic wr_sel_data, rd_sel_data, rd_sel_stat, rd_sel_msr;
  assign wr_sel_data = wr_en && (addr == ADDR_W'(OFS_DATA));
  assign rd_sel_data = rd_en && (addr == ADDR_W'(OFS_DATA));
  assign rd_sel_stat = rd_en && (addr == ADDR_W'(OFS_STAT));
  assign rd_sel_msr  = rd_en && (addr == ADDR_W'(OFS_MSTAT));

  fmt_t fmt;
  logic [LIM_W-1:0] lim;
  assign fmt = fmt_t'(mode[3:0]);
  assign lim = tick_limit(baud, mode[7:4]);

  logic tick, tx_busy, thr_full, tx_start, tx_ld, tx_go;
  logic rx_done, rx_active;
  rxres_t rx_res;

  assign tx_ld = wr_sel_data && ctrl[1] && !thr_full;
  assign tx_go = ctrl[1] && (!ctrl[3] || cts_eff);

  uart_modem_baud u_baud (
    .clk(clk), .rst_n(rst_n), .lim(lim), .tick(tick)
  );

  uart_modem_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld(tx_ld), .ld_data(wdata),
    .fmt(fmt), .go_ok(tx_go), .txd(txd), .busy(tx_busy),
    .thr_full(thr_full), .start(tx_start)
  );

  uart_modem_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_s(rxd_s), .en(ctrl[0]),
    .fmt(fmt), .done(rx_done), .res(rx_res), .active(rx_active)
  );

  assign status = {msc, ovr, ferr, perr, tx_busy, rx_active, !thr_full, rx_full};

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(OFS_CTRL):  rdata = ctrl;
      ADDR_W'(OFS_MODE):  rdata = mode;
      ADDR_W'(OFS_BAUD):  rdata = baud;
      ADDR_W'(OFS_STAT):  rdata = status;
      ADDR_W'(OFS_DATA):  rdata = rbr;
      ADDR_W'(OFS_MCTL):  rdata = mctl;
      ADDR_W'(OFS_MSTAT): rdata = {4'd0, ml};
      default:            rdata = '0;
    endcase
  end

  assign irq = |(ctrl[7:4] & {msc, ovr | ferr | perr, !thr_full, rx_full});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; mode <= '0; baud <= '0; mctl <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_W'(OFS_CTRL): ctrl <= wdata;
        ADDR_W'(OFS_MODE): mode <= wdata;
        ADDR_W'(OFS_BAUD): baud <= wdata;
        ADDR_W'(OFS_MCTL): mctl <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr <= '0; rx_full <= 1'b0; ovr <= 1'b0; ferr <= 1'b0; perr <= 1'b0;
    end else begin
      if (rd_sel_data) rx_full <= 1'b0;
      if (rd_sel_stat) begin
        ovr <= 1'b0; ferr <= 1'b0; perr <= 1'b0;
      end
      if (rx_done) begin
        if (rx_full) begin
          ovr <= 1'b1;
        end else begin
          rbr     <= rx_res.data;
          rx_full <= 1'b1;
          if (rx_res.perr) perr <= 1'b1;
          if (rx_res.ferr) ferr <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msc <= 1'b0; prev_ml <= '0;
    end else begin
      prev_ml <= ml;
      if (rd_sel_msr) msc <= 1'b0;
      if (mctl[2] && (ml != prev_ml)) msc <= 1'b1;
    end
  end

  a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full) |=> ovr);
  a_r7_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full) |=> $stable(rbr));
  a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_stat && !rx_done) |=> ({ovr, ferr, perr} == 3'b000));
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!mctl[2] && !msc) |=> !msc);
  a_r10_flow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[3] && !cts_eff) |-> !tx_start);
endmodule

// File: tb/tb_uart_modem.sv
`timescale 1ns/1ps
module tb_uart_modem;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, rd_en, wr_en, txd, rxd, brx, loop;
  logic cts_i, dsr_i, dcd_i, ri_i, rts_o, dtr_o, irq;
  logic [5:0] addr;
  logic [7:0] wdata, rdata;
  int total = 0, bad = 0;
  bit finished = 0;

  assign rxd = loop ? txd : brx;

  uart_modem dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd), .cts_i(cts_i),
    .dsr_i(dsr_i), .dcd_i(dcd_i), .ri_i(ri_i), .rts_o(rts_o), .dtr_o(dtr_o),
    .irq(irq)
  );

  // {baud, mode, data, expected received byte}
  localparam logic [31:0] VEC [6] = '{
    {8'h00, 8'h00, 8'hA5, 8'hA5},
    {8'h01, 8'h06, 8'h3C, 8'h3C},
    {8'h00, 8'h12, 8'h81, 8'h81},
    {8'h00, 8'h09, 8'hD3, 8'h53},
    {8'h02, 8'h0F, 8'h7F, 8'h7F},
    {8'h00, 8'h0A, 8'h00, 8'h00}
  };

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rdchk(logic [5:0] a, logic [7:0] exp, string tag);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  function automatic int flen(logic [7:0] m);
    return 1 + (m[0] ? 7 : 8) + (m[1] ? 1 : 0) + (m[3] ? 2 : 1);
  endfunction

  function automatic int period(logic [7:0] b, logic [7:0] m);
    return 16 * (int'(b) + 1) * (int'(m[7:4]) + 1);
  endfunction

  // line bits, first transmitted in bit 0
  function automatic logic [11:0] fbits(logic [7:0] d, logic [7:0] m);
    logic [11:0] v;
    int n, ones;
    n = m[0] ? 7 : 8;
    v = 12'hFFF;
    v[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      v[i+1] = d[i];
      if (d[i]) ones++;
    end
    if (m[1]) v[n+1] = m[2] ? (ones % 2 == 0) : (ones % 2 == 1);
    return v;
  endfunction

  task automatic check_tx(logic [7:0] d, logic [7:0] m, int p, string tag);
    logic [11:0] got, exp;
    int n, w;
    n = flen(m);
    exp = fbits(d, m);
    got = 12'hFFF;
    w = 0;
    while (txd !== 1'b0 && w < 5000) begin @(negedge clk); w++; end
    idle(p / 2);
    for (int i = 0; i < n; i++) begin
      got[i] = txd;
      idle(p);
    end
    chk(tag, int'(got), int'(exp));
  endtask

  task automatic send_rx(logic [7:0] d, logic [7:0] m, bit bad_par, bit bad_stop, int p);
    logic [11:0] v;
    int n, dl;
    v = fbits(d, m);
    n = flen(m);
    dl = m[0] ? 7 : 8;
    if (bad_par) v[dl+1] = ~v[dl+1];
    if (bad_stop) v[dl+1+(m[1] ? 1 : 0)] = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); brx = v[i];
      idle(p - 1);
    end
    @(negedge clk); brx = 1'b1;
    idle(p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL all: watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    int p, cnt;
    rst_n = 0; rd_en = 0; wr_en = 0; addr = '0; wdata = '0;
    brx = 1; loop = 0; cts_i = 0; dsr_i = 0; dcd_i = 0; ri_i = 0;
    idle(5);
    rst_n = 1;
    idle(2);

    // R1 reset state and readback
    chk("R1 txd", txd, 1);
    chk("R1 irq", irq, 0);
    chk("R1 rts/dtr", {rts_o, dtr_o}, 0);
    rdchk(6'h0C, 8'h02, "R1 status");
    rdchk(6'h00, 8'h00, "R1 ctrl");
    rdchk(6'h14, 8'h00, "R1 mctl");
    wr(6'h04, 8'h5A); rdchk(6'h04, 8'h5A, "R1 mode readback");
    wr(6'h08, 8'h33); rdchk(6'h08, 8'h33, "R1 baud readback");
    wr(6'h04, 8'h00); wr(6'h08, 8'h00);

    // R3 / R5 table in loopback
    loop = 1;
    wr(6'h00, 8'h03);
    foreach (VEC[i]) begin
      wr(6'h08, VEC[i][31:24]);
      wr(6'h04, VEC[i][23:16]);
      p = period(VEC[i][31:24], VEC[i][23:16]);
      wr(6'h10, VEC[i][15:8]);
      check_tx(VEC[i][15:8], VEC[i][23:16], p, "R3 frame");
      idle(p);
      rdchk(6'h0C, 8'h03, "R5 status after char");
      rdchk(6'h10, VEC[i][7:0], "R5 data");
    end

    // R2 bit length, R4 active flag
    wr(6'h08, 8'h01); wr(6'h04, 8'h10);
    wr(6'h10, 8'h55);
    cnt = 0;
    while (txd !== 1'b0 && cnt < 5000) begin @(negedge clk); cnt++; end
    while (txd !== 1'b1 && cnt < 10000) begin @(negedge clk); cnt++; end
    cnt = 0;
    while (txd === 1'b1 && cnt < 5000) begin @(negedge clk); cnt++; end
    chk("R2 bit period", cnt, 64);
    rd(6'h0C, st);
    chk("R4 tx active", st[3], 1);
    idle(12 * 64);
    rdchk(6'h10, 8'h55, "R5 data at slow rate");
    wr(6'h08, 8'h00); wr(6'h04, 8'h00);

    // R4 write ignored while transmitter disabled
    wr(6'h00, 8'h01);
    wr(6'h10, 8'h77);
    idle(40);
    chk("R4 disabled txd", txd, 1);
    rdchk(6'h0C, 8'h02, "R4 disabled status");

    // R10 hardware flow, R4 write while full ignored
    wr(6'h00, 8'h0B);
    wr(6'h10, 8'h11);
    wr(6'h10, 8'h22);
    idle(100);
    chk("R10 held txd", txd, 1);
    rdchk(6'h0C, 8'h00, "R10 held status");
    cts_i = 1;
    check_tx(8'h11, 8'h00, 16, "R4 first byte kept");
    idle(16);
    rdchk(6'h10, 8'h11, "R10 loopback data");
    cts_i = 0;
    wr(6'h00, 8'h03);
    wr(6'h10, 8'h44);
    check_tx(8'h44, 8'h00, 16, "R10 software flow ignores cts");
    idle(16);
    rdchk(6'h10, 8'h44, "R10 loopback data sw");

    // R6 / R7 / R5 bench-driven receive
    loop = 0;
    wr(6'h00, 8'h01);
    wr(6'h04, 8'h02);
    send_rx(8'h01, 8'h02, 1, 0, 16);
    rdchk(6'h0C, 8'h13, "R6 parity error");
    rdchk(6'h0C, 8'h03, "R7 status read clears");
    rdchk(6'h10, 8'h01, "R6 data with parity error");
    wr(6'h04, 8'h00);
    send_rx(8'h0F, 8'h00, 0, 1, 16);
    rdchk(6'h0C, 8'h23, "R6 framing error");
    rdchk(6'h10, 8'h0F, "R6 data with framing error");
    rdchk(6'h0C, 8'h02, "R7 cleared after framing");
    send_rx(8'h11, 8'h00, 0, 0, 16);
    send_rx(8'h22, 8'h00, 0, 0, 16);
    rdchk(6'h0C, 8'h43, "R7 overrun");
    rdchk(6'h10, 8'h11, "R7 old byte kept");
    rdchk(6'h0C, 8'h02, "R7 overrun cleared");
    wr(6'h04, 8'h01);
    send_rx(8'hFF, 8'h01, 0, 0, 16);
    rdchk(6'h10, 8'h7F, "R5 7-bit data");
    wr(6'h04, 8'h00);
    wr(6'h00, 8'h00);
    send_rx(8'h5A, 8'h00, 0, 0, 16);
    rdchk(6'h0C, 8'h02, "R5 receiver disabled");

    // R11 interrupt sources
    wr(6'h00, 8'h11);
    send_rx(8'h33, 8'h00, 0, 0, 16);
    chk("R11 rx irq", irq, 1);
    rdchk(6'h10, 8'h33, "R11 rx data");
    chk("R11 rx irq cleared", irq, 0);
    wr(6'h00, 8'h20);
    idle(1);
    chk("R11 tx empty irq", irq, 1);
    wr(6'h00, 8'h41);
    wr(6'h04, 8'h02);
    send_rx(8'h01, 8'h02, 1, 0, 16);
    chk("R11 error irq", irq, 1);
    rdchk(6'h0C, 8'h13, "R11 error status");
    chk("R11 error irq cleared", irq, 0);
    rdchk(6'h10, 8'h01, "R11 drain");
    wr(6'h04, 8'h00);
    wr(6'h00, 8'h00);

    // R8 / R9 modem lines
    wr(6'h14, 8'h03);
    chk("R8 rts/dtr on", {rts_o, dtr_o}, 3);
    wr(6'h14, 8'h00);
    cts_i = 1; ri_i = 1;
    idle(5);
    rdchk(6'h20, 8'h09, "R8 modem status");
    rdchk(6'h0C, 8'h02, "R9 no flag when off");
    wr(6'h14, 8'h04);
    idle(3);
    dsr_i = 1;
    idle(5);
    rdchk(6'h0C, 8'h82, "R9 change flag");
    wr(6'h00, 8'h80);
    idle(1);
    chk("R11 modem irq", irq, 1);
    rdchk(6'h20, 8'h0B, "R8 modem status 2");
    rdchk(6'h0C, 8'h02, "R9 flag cleared");
    chk("R11 modem irq cleared", irq, 0);
    wr(6'h14, 8'h0F);
    idle(3);
    rdchk(6'h0C, 8'h82, "R9 null-modem change");
    rdchk(6'h20, 8'h07, "R8 null-modem loop");
    rdchk(6'h0C, 8'h02, "R9 cleared after null");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule